// File: doc/BRIEF.md
# Locked Instruction-Memory Write Port

This block sits on a processor's data bus and gives software a narrow, guarded path into the separate instruction memory. Three write-only registers in the upper half of a 17-bit data-bus window control it: a key register that arms or disarms the path, a pointer register that holds the target instruction-memory address, and a data register whose writes become instruction-memory writes.

A data-register write is turned into an instruction-memory write only while the path is armed, and each accepted write moves the pointer forward by one 32-bit word. Software can therefore arm once, load the pointer once and stream a block of code with consecutive data-register writes. The access size that comes with the bus write is passed on, and so are an aligned address, byte enables and lane-replicated data. Bus writes to the lower half of the window are RAM traffic and are passed to the RAM write enable without touching the port.

Top module: `pmem_wr_port`

## Requirements
- R1: After reset the path is disarmed, the pointer is 0 and `pm_we_o` is low, so a data write issued right after reset produces no strobe.
- R2: Only bits 16:0 of `bus_addr_i` are decoded. Bits 31:17 are ignored, so a write to 0xABC1FC84 loads the pointer.
- R3: A write to offset 0x1FC80 arms the path when the written value is 0x1337F7D1 and disarms it for any other value.
- R4: A write to offset 0x1FC84 loads the full 32-bit written value into the pointer.
- R5: An armed write to offset 0x1FC88 raises `pm_we_o` for exactly the next clock cycle, with `pm_wdata_o`, `pm_size_o` and `pm_addr_o` taken from that write and the current pointer.
- R6: A disarmed write to offset 0x1FC88 raises no strobe and leaves the pointer unchanged.
- R7: Each accepted data write adds 4 to the pointer, whatever the access size.
- R8: Size codes are 0 = byte, 1 = halfword, 2 = word (3 behaves as word). `pm_addr_o` is the pointer with bit 0 cleared for halfwords and bits 1:0 cleared for words. A byte keeps every bit.
- R9: Byte enables (bit n enables byte lane n, i.e. bits 8n+7:8n): byte sets bit addr[1:0], halfword sets 4'b0011 or 4'b1100 by addr[1], word sets 4'b1111. Byte data is replicated to all four lanes, halfword data to both halves, and word data passes unchanged.
- R10: The armed state persists across any number of data writes until the key register is written again.
- R11: A write with bus address bit 16 clear drives `ram_we_o` in the same cycle with `ram_addr_o` = bus address bits 15:0, and it never changes the armed state, the pointer or `pm_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Data-bus write valid |
| bus_addr_i | input | 32 | Data-bus byte address |
| bus_size_i | input | 2 | Access size code |
| bus_wdata_i | input | 32 | Data-bus write data |
| ram_we_o | output | 1 | RAM-space write enable (combinational) |
| ram_addr_o | output | 16 | RAM-space byte address |
| pm_we_o | output | 1 | Instruction-memory write strobe |
| pm_addr_o | output | 32 | Aligned instruction-memory byte address |
| pm_be_o | output | 4 | Byte lane enables |
| pm_wdata_o | output | 32 | Lane-replicated write data |
| pm_size_o | output | 2 | Forwarded access size |

## Verification
The bench first tries a data write right after reset and after a wrong key. A design that armed by default, or on any key write, would then corrupt instruction memory. It streams several writes after a single arm to catch an armed state that clears itself, and it checks that the pointer keeps its value across ignored writes and RAM writes. A design that incremented the pointer there would misplace the next word. Halfword and byte writes at odd pointers test the alignment, lane enables and replication, where a wrong mask would merge bytes into the wrong word. Finally, writes with high address bits set show whether the 17-bit masking is in place.

// File: rtl/pmwp_pkg.sv
package pmwp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // clear the low address bits that a size does not resolve
   function automatic logic [31:0] align_addr(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] r;
      r = a;
      case (sz)
         SZ_BYTE: r = a;
         SZ_HALF: r = {a[31:1], 1'b0};
         default: r = {a[31:2], 2'b00};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pmwp_decode.sv
module pmwp_decode #(
   parameter int          BUS_AW   = 17,
   parameter logic [31:0] OFS_KEY  = 32'h1FC80,
   parameter logic [31:0] OFS_PTR  = 32'h1FC84,
   parameter logic [31:0] OFS_DATA = 32'h1FC88
) (
   input  logic              bus_wr_i,
   input  logic [31:0]       bus_addr_i,
   output logic              key_hit_o,
   output logic              ptr_hit_o,
   output logic              data_hit_o,
   output logic              ram_hit_o,
   output logic [BUS_AW-2:0] ram_addr_o
);
   localparam int IO_BIT = BUS_AW - 1;

   if (BUS_AW < 2 || BUS_AW > 31) begin : g_bad_aw
      $error("pmwp_decode: BUS_AW out of range");
   end

   logic [BUS_AW-1:0] masked;
   logic              io_space;
   logic              unused_hi;

   assign masked    = bus_addr_i[BUS_AW-1:0];
   assign unused_hi = ^bus_addr_i[31:BUS_AW];
   assign io_space  = masked[IO_BIT];

   assign key_hit_o  = bus_wr_i && io_space && (masked == OFS_KEY[BUS_AW-1:0]);
   assign ptr_hit_o  = bus_wr_i && io_space && (masked == OFS_PTR[BUS_AW-1:0]);
   assign data_hit_o = bus_wr_i && io_space && (masked == OFS_DATA[BUS_AW-1:0]);
   assign ram_hit_o  = bus_wr_i && !io_space;
   assign ram_addr_o = masked[BUS_AW-2:0];

endmodule

// File: rtl/pmwp_regs.sv
module pmwp_regs #(
   parameter int          ADDR_W = 32,
   parameter int          STEP   = 4,
   parameter logic [31:0] KEY    = 32'h1337F7D1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_hit_i,
   input  logic              ptr_hit_i,
   input  logic              data_hit_i,
   input  logic [31:0]       wdata_i,
   output logic              armed_o,
   output logic              accept_o,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (ADDR_W != 32) begin : g_bad_w
      $error("pmwp_regs: ADDR_W must be 32");
   end

   logic              armed_q;
   logic [ADDR_W-1:0] ptr_q;

   assign accept_o = data_hit_i && armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ptr_q   <= '0;
      end else begin
         if (key_hit_i) armed_q <= (wdata_i == KEY);
         if (ptr_hit_i)     ptr_q <= wdata_i;
         else if (accept_o) ptr_q <= ptr_q + STEP_V;
      end
   end

   assign armed_o = armed_q;
   assign ptr_o   = ptr_q;

   // R7
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> ptr_q == $past(ptr_q) + STEP_V);
   // R6
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit_i && !armed_q) |=> $stable(ptr_q) && !armed_q);
   // R3
   key_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit_i && wdata_i == KEY) |=> armed_q);
   // R3
   key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit_i && wdata_i != KEY) |=> !armed_q);

endmodule

// File: rtl/pmwp_lane.sv
module pmwp_lane
   import pmwp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [31:0]       ptr_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              pm_we_o,
   output logic [31:0]       pm_addr_o,
   output logic [DATA_W/8-1:0] pm_be_o,
   output logic [DATA_W-1:0] pm_wdata_o,
   output logic [1:0]        pm_size_o
);
   localparam int NBYTES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_dw
      $error("pmwp_lane: DATA_W must be 32");
   end

   logic [NBYTES-1:0] be_d;
   logic [DATA_W-1:0] data_d;

   always_comb begin
      case (size_i)
         SZ_BYTE: be_d = NBYTES'(1) << ptr_i[1:0];
         SZ_HALF: be_d = ptr_i[1] ? 4'b1100 : 4'b0011;
         default: be_d = '1;
      endcase
   end

   if (REPLICATE) begin : g_repl
      always_comb begin
         case (size_i)
            SZ_BYTE: data_d = {NBYTES{wdata_i[7:0]}};
            SZ_HALF: data_d = {(NBYTES/2){wdata_i[15:0]}};
            default: data_d = wdata_i;
         endcase
      end
   end else begin : g_raw
      assign data_d = wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pm_we_o    <= 1'b0;
         pm_addr_o  <= '0;
         pm_be_o    <= '0;
         pm_wdata_o <= '0;
         pm_size_o  <= '0;
      end else begin
         pm_we_o <= accept_i;
         if (accept_i) begin
            pm_addr_o  <= align_addr(ptr_i, size_i);
            pm_be_o    <= be_d;
            pm_wdata_o <= data_d;
            pm_size_o  <= size_i;
         end
      end
   end

   // R5
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we_o |-> $past(accept_i));
   // R9
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_we_o && pm_size_o == SZ_BYTE) |-> $countones(pm_be_o) == 1);
   // R8
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_we_o && pm_size_o == SZ_WORD) |-> pm_addr_o[1:0] == 2'b00);

endmodule

// File: rtl/pmem_wr_port.sv
module pmem_wr_port
   import pmwp_pkg::*;
#(
   parameter int          BUS_AW    = 17,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] UNLOCK_KEY = 32'h1337F7D1,
   parameter bit          REPLICATE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr_i,
   input  logic [31:0] bus_addr_i,
   input  logic [1:0]  bus_size_i,
   input  logic [31:0] bus_wdata_i,
   output logic        ram_we_o,
   output logic [15:0] ram_addr_o,
   output logic        pm_we_o,
   output logic [31:0] pm_addr_o,
   output logic [3:0]  pm_be_o,
   output logic [31:0] pm_wdata_o,
   output logic [1:0]  pm_size_o
);
   if (BUS_AW != 17) begin : g_bad_top
      $error("pmem_wr_port: RAM address port assumes BUS_AW of 17");
   end

   logic        key_hit, ptr_hit, data_hit;
   logic        armed, accept;
   logic [31:0] ptr;

   pmwp_decode #(.BUS_AW(BUS_AW)) u_dec (
      .bus_wr_i  (bus_wr_i),
      .bus_addr_i(bus_addr_i),
      .key_hit_o (key_hit),
      .ptr_hit_o (ptr_hit),
      .data_hit_o(data_hit),
      .ram_hit_o (ram_we_o),
      .ram_addr_o(ram_addr_o)
   );

   pmwp_regs #(.ADDR_W(32), .STEP(4), .KEY(UNLOCK_KEY)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_hit_i (key_hit),
      .ptr_hit_i (ptr_hit),
      .data_hit_i(data_hit),
      .wdata_i   (bus_wdata_i),
      .armed_o   (armed),
      .accept_o  (accept),
      .ptr_o     (ptr)
   );

   pmwp_lane #(.DATA_W(DATA_W), .REPLICATE(REPLICATE)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .ptr_i     (ptr),
      .size_i    (bus_size_i),
      .wdata_i   (bus_wdata_i),
      .pm_we_o   (pm_we_o),
      .pm_addr_o (pm_addr_o),
      .pm_be_o   (pm_be_o),
      .pm_wdata_o(pm_wdata_o),
      .pm_size_o (pm_size_o)
   );

   // R11
   ram_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |=> !pm_we_o);
   // R11
   ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |=> $stable(armed) && $stable(ptr));
   // R10
   arm_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !key_hit) |=> armed);

endmodule

// File: tb/pmem_wr_port_tb.sv
module pmem_wr_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [31:0] bus_addr_i = '0;
   logic [1:0]  bus_size_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic        ram_we_o;
   logic [15:0] ram_addr_o;
   logic        pm_we_o;
   logic [31:0] pm_addr_o;
   logic [3:0]  pm_be_o;
   logic [31:0] pm_wdata_o;
   logic [1:0]  pm_size_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] mem [0:63];

   localparam logic [31:0] A_KEY = 32'h1FC80;
   localparam logic [31:0] A_PTR = 32'h1FC84;
   localparam logic [31:0] A_DAT = 32'h1FC88;
   localparam logic [31:0] KEY   = 32'h1337F7D1;

   always #5 clk = ~clk;

   pmem_wr_port dut_i (.*);

   // instruction memory model, lane-masked
   always @(posedge clk) begin
      if (pm_we_o && pm_addr_o < 32'h100) begin
         for (int b = 0; b < 4; b++)
            if (pm_be_o[b]) mem[pm_addr_o[7:2]][8*b +: 8] <= pm_wdata_o[8*b +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus write; returns at the negedge after the capturing posedge
   task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_size_i = sz; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic t_reset;
      chk(pm_we_o == 1'b0, "R1 strobe", 32'(pm_we_o), 0);
      chk(pm_addr_o == 0, "R1 addr", pm_addr_o, 0);
      wr(A_DAT, 2'd2, 32'hDEAD0001);
      chk(pm_we_o == 1'b0, "R1 no strobe when disarmed", 32'(pm_we_o), 0);
   endtask

   task automatic t_locked;
      wr(A_KEY, 2'd2, 32'h1337F7D0);
      wr(A_DAT, 2'd2, 32'hDEAD0002);
      chk(pm_we_o == 1'b0, "R3 wrong key", 32'(pm_we_o), 0);
      wr(A_KEY, 2'd2, KEY);
      wr(A_DAT, 2'd2, 32'h11111111);
      chk(pm_we_o == 1'b1, "R5 strobe", 32'(pm_we_o), 1);
      chk(pm_addr_o == 0, "R6 pointer kept at 0", pm_addr_o, 0);
      chk(pm_wdata_o == 32'h11111111, "R5 data", pm_wdata_o, 32'h11111111);
      chk(pm_size_o == 2'd2, "R5 size", 32'(pm_size_o), 2);
      @(negedge clk);
      chk(pm_we_o == 1'b0, "R5 single cycle", 32'(pm_we_o), 0);
      wr(A_KEY, 2'd2, 32'h0);
      wr(A_DAT, 2'd2, 32'hDEAD0003);
      chk(pm_we_o == 1'b0, "R3 disarm", 32'(pm_we_o), 0);
   endtask

   task automatic t_stream;
      wr(A_KEY, 2'd2, KEY);
      wr(A_PTR, 2'd2, 32'h00012340);
      for (int i = 0; i < 3; i++) begin
         wr(A_DAT, 2'd2, 32'hA0 + i);
         chk(pm_we_o == 1'b1, "R10 still armed", 32'(pm_we_o), 1);
         chk(pm_addr_o == 32'h12340 + 4*i, "R4 R7 pointer", pm_addr_o, 32'h12340 + 4*i);
      end
   endtask

   task automatic t_align;
      wr(A_PTR, 2'd2, 32'h43);
      wr(A_DAT, 2'd1, 32'hAAAABEEF);
      chk(pm_addr_o == 32'h42, "R8 half align", pm_addr_o, 32'h42);
      chk(pm_be_o == 4'b1100, "R9 half be", 32'(pm_be_o), 32'hC);
      chk(pm_wdata_o == 32'hBEEFBEEF, "R9 half repl", pm_wdata_o, 32'hBEEFBEEF);
      wr(A_DAT, 2'd0, 32'h1234565A);
      chk(pm_addr_o == 32'h47, "R8 byte addr", pm_addr_o, 32'h47);
      chk(pm_be_o == 4'b1000, "R9 byte be", 32'(pm_be_o), 32'h8);
      chk(pm_wdata_o == 32'h5A5A5A5A, "R9 byte repl", pm_wdata_o, 32'h5A5A5A5A);
      wr(A_DAT, 2'd2, 32'hCAFEF00D);
      chk(pm_addr_o == 32'h48, "R8 word align", pm_addr_o, 32'h48);
      chk(pm_be_o == 4'b1111, "R9 word be", 32'(pm_be_o), 32'hF);
      @(negedge clk);
      chk(mem[16] == 32'hBEEF0000, "R9 half merge", mem[16], 32'hBEEF0000);
      chk(mem[17] == 32'h5A000000, "R9 byte merge", mem[17], 32'h5A000000);
      chk(mem[18] == 32'hCAFEF00D, "R9 word store", mem[18], 32'hCAFEF00D);
   endtask

   task automatic t_mask;
      wr(32'hABC1FC84, 2'd2, 32'h80);
      wr(32'hFFFFFC88, 2'd2, 32'h77);
      chk(pm_we_o == 1'b1, "R2 masked data hit", 32'(pm_we_o), 1);
      chk(pm_addr_o == 32'h80, "R2 masked pointer", pm_addr_o, 32'h80);
   endtask

   task automatic t_ram;
      bus_wr_i = 1'b1; bus_addr_i = 32'h0000FC88; bus_size_i = 2'd2; bus_wdata_i = KEY;
      #1;
      chk(ram_we_o == 1'b1, "R11 ram we", 32'(ram_we_o), 1);
      chk(ram_addr_o == 16'hFC88, "R11 ram addr", 32'(ram_addr_o), 32'hFC88);
      @(negedge clk);
      bus_wr_i = 1'b0;
      chk(pm_we_o == 1'b0, "R11 no strobe", 32'(pm_we_o), 0);
      wr(32'h0000FC84, 2'd2, 32'h500);
      wr(A_DAT, 2'd2, 32'h99);
      chk(pm_addr_o == 32'h84, "R11 pointer untouched", pm_addr_o, 32'h84);
      wr(A_PTR, 2'd2, 32'hFFFFFFFC);
      wr(A_DAT, 2'd2, 32'h1);
      wr(A_DAT, 2'd2, 32'h2);
      chk(pm_addr_o == 32'h0, "R4 R7 full width wrap", pm_addr_o, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_locked;
      t_stream;
      t_align;
      t_mask;
      t_ram;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule